// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration and Readback Sequencer

This block is a hardware master for the byte-wide slave configuration port of a target FPGA. It produces the target's program request, chip select, write strobe and configuration clock. It drives an 8-bit data bus, split into an output, an output enable and an input so that a pad ring can form the bidirectional pins. It watches the target's INIT, BUSY and DONE status lines. Every pin change happens on a phase boundary of `PHASE` system clocks. Every wait on the target is bounded by a window of `TIMEOUT` system clocks.

The block has two operations, and each is started by a one-cycle pulse. A load sends `xfer_len` bytes from a valid/ready input stream into the target. It first resets the target and then waits for the target to become ready. The byte rate follows the target's BUSY line: while BUSY is high, the block keeps pulsing the clock with the same byte on the bus. After the last byte it keeps clocking until DONE rises. A readback takes `xfer_len` bytes from the target and presents them on a valid/ready output stream. Each operation ends with a one-cycle `op_end` pulse, and `op_ok` gives its outcome.

Both streams follow the same back-pressure rule: a byte moves on a clock edge where valid and ready are both high. The input stream is asked for a byte only when the target can take one, and `ld_valid` may go low between bytes. The output stream holds `rb_valid` and `rb_data` steady until `rb_ready` is seen. While it waits, the configuration clock stays high and no new byte is read.

Top module: `fpga_cfg_master`

## Requirements
- R1: After reset, `tgt_prog`, `tgt_cs`, `tgt_wr`, `tgt_doe`, `ld_ready`, `rb_valid` and `active` are 0, and `tgt_cclk` is 1.
- R2: A load holds `tgt_prog` at 1 for exactly PHASE cycles with chip select and write low. It then waits until the target is ready, which means INIT and BUSY are not both 1. If the target is not ready within TIMEOUT cycles, the load ends with `op_ok`=0.
- R3: Before any data is sent, write rises while chip select is still low, and chip select rises PHASE cycles later. The clock stays high until the first byte is presented.
- R4: Each load byte is taken from the input stream only while clock, chip select and write are all high. It is placed on `tgt_dout` with `tgt_doe`=1 and is held through a low phase and the following rising clock edge. The target receives the bytes in stream order, one stream handshake per byte.
- R5: When BUSY is 1 at the end of a byte's high phase, the block gives further low-high clock pulses with the same byte on the bus and takes no new byte until BUSY is 0. If BUSY stays 1 for TIMEOUT cycles, the load ends with `op_ok`=0.
- R6: After the last load byte, chip select falls while write is still high, and write falls PHASE cycles later.
- R7: After write falls, the block gives low-high clock pulses until DONE is 1, and then ends with `op_ok`=1. If DONE is still 0 after TIMEOUT cycles, the load ends with `op_ok`=0.
- R8: A readback raises chip select with write low and never drives the bus. For each byte it pulses the clock low and then high, samples `tgt_din` at the end of the high phase and offers the byte on `rb_valid`/`rb_data`. That byte stays stable with the clock held high until `rb_ready` is seen.
- R9: A readback ends by dropping chip select and giving exactly one more low-high clock pulse. It then ends with `op_ok`=1.
- R10: When `xfer_len` is 0, a load still runs the reset, strobe and DONE sequence and takes no byte. A readback with `xfer_len` 0 reads no byte.
- R11: `tgt_doe` is 1 only while write is asserted during a load.
- R12: A start pulse of either kind is ignored while an operation is active: only one `op_end` follows, and the running load delivers its bytes unchanged.
- R13: At the end of every operation, and after any failure, chip select, write and `tgt_doe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | One-cycle pulse that starts a load |
| start_read | input | 1 | One-cycle pulse that starts a readback (load wins if both are set) |
| xfer_len | input | LEN_W | Number of bytes, latched at start |
| ld_valid | input | 1 | Load stream byte valid |
| ld_data | input | DW | Load stream byte |
| ld_ready | output | 1 | Load stream ready |
| rb_valid | output | 1 | Readback stream byte valid |
| rb_data | output | DW | Readback stream byte |
| rb_ready | input | 1 | Readback stream ready |
| tgt_prog | output | 1 | Program request to the target, 1 = asserted |
| tgt_cs | output | 1 | Chip select, 1 = asserted |
| tgt_wr | output | 1 | Write strobe, 1 = asserted |
| tgt_cclk | output | 1 | Configuration clock |
| tgt_dout | output | DW | Data bus driven value |
| tgt_doe | output | 1 | Data bus output enable |
| tgt_din | input | DW | Data bus sampled value |
| tgt_init | input | 1 | Target INIT status, 1 = still initialising |
| tgt_busy | input | 1 | Target BUSY status, 1 = busy |
| tgt_done | input | 1 | Target DONE status, 1 = configured |
| active | output | 1 | An operation is in progress |
| op_end | output | 1 | One-cycle pulse at the end of an operation |
| op_ok | output | 1 | Outcome of the last operation, valid with op_end |

## Verification
The checker verifies the pin protocol on every cycle. These checks cover the order of write against chip select at both ends of a load, the program request with both strobes low, and the bus enable only under write. They also cover a held byte across each rising clock edge, the input stream pulled only while the clock is high with both strobes set, the readback byte and the high clock during a stall, and both strobes released at every operation end. Only the bench scenarios can show that the bytes arrive in order and match the source, and that BUSY-driven repeat pulses keep the byte while capturing nothing new. The same holds for the exact DONE pulse count, the single trailing pulse of a readback, the three timeout outcomes and the start pulses that are ignored, because each of these depends on a target model and a stream that the bench supplies.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_L_PROG, S_L_WAIT, S_L_WR, S_L_CS, S_L_CKH,
    S_L_FETCH, S_L_LO, S_L_HI, S_L_BLO, S_L_BHI,
    S_L_ECS, S_L_EWR, S_L_DCHK, S_L_DLO, S_L_DHI,
    S_R_CS, S_R_CKH, S_R_LO, S_R_HI, S_R_OUT,
    S_R_ECS, S_R_FLO, S_R_FHI
  } cfgm_state_e;

  // configuration clock is low only in the low phase states
  function automatic logic st_cclk(cfgm_state_e s);
    return !(s inside {S_L_LO, S_L_BLO, S_L_DLO, S_R_LO, S_R_FLO});
  endfunction

  function automatic logic st_wr(cfgm_state_e s);
    return s inside {S_L_WR, S_L_CS, S_L_CKH, S_L_FETCH, S_L_LO,
                     S_L_HI, S_L_BLO, S_L_BHI, S_L_ECS};
  endfunction

  function automatic logic st_cs(cfgm_state_e s);
    return s inside {S_L_CS, S_L_CKH, S_L_FETCH, S_L_LO, S_L_HI,
                     S_L_BLO, S_L_BHI,
                     S_R_CS, S_R_CKH, S_R_LO, S_R_HI, S_R_OUT};
  endfunction

  // states whose wait on the target is bounded by the window timer
  function automatic logic st_timed(cfgm_state_e s);
    return s inside {S_L_WAIT, S_L_BLO, S_L_BHI, S_L_DCHK, S_L_DLO, S_L_DHI};
  endfunction

endpackage

// File: rtl/cfgm_phase_gen.sv
module cfgm_phase_gen #(
  parameter int PHASE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PHASE > 1) ? $clog2(PHASE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/cfgm_window_timer.sv
module cfgm_window_timer #(
  parameter int TIMEOUT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (en && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/cfgm_byte_ctr.sv
module cfgm_byte_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] total_in,
  input  logic             inc,
  output logic             all_done,
  output logic             at_last
);
  logic [LEN_W-1:0] total_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      total_q <= total_in;
      cnt_q   <= '0;
    end else if (inc) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign all_done = (cnt_q == total_q);
  assign at_last  = (total_q != '0) && (cnt_q == total_q - 1'b1);
endmodule

// File: rtl/fpga_cfg_master.sv
module fpga_cfg_master
  import cfgm_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LEN_W      = 16,
  parameter int PHASE      = 4,
  parameter int TIMEOUT    = 1000000,
  parameter bit CHECK_BUSY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_load,
  input  logic             start_read,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             ld_valid,
  input  logic [DW-1:0]    ld_data,
  output logic             ld_ready,
  output logic             rb_valid,
  output logic [DW-1:0]    rb_data,
  input  logic             rb_ready,
  output logic             tgt_prog,
  output logic             tgt_cs,
  output logic             tgt_wr,
  output logic             tgt_cclk,
  output logic [DW-1:0]    tgt_dout,
  output logic             tgt_doe,
  input  logic [DW-1:0]    tgt_din,
  input  logic             tgt_init,
  input  logic             tgt_busy,
  input  logic             tgt_done,
  output logic             active,
  output logic             op_end,
  output logic             op_ok
);

  cfgm_state_e state_q, state_d;
  logic tick, tmr_exp, all_done, at_last;
  logic tmr_clr, cnt_load, cnt_inc, dout_ld, rb_ld, fin, fin_ok;
  logic [DW-1:0] dout_q, rb_q;
  logic end_q, ok_q;
  logic tgt_ready, byte_next;

  assign tgt_ready = !(tgt_init && tgt_busy);

  cfgm_phase_gen #(.PHASE(PHASE)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(state_d != state_q), .tick(tick)
  );

  cfgm_window_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(st_timed(state_q)),
    .expired(tmr_exp)
  );

  cfgm_byte_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .total_in(xfer_len),
    .inc(cnt_inc), .all_done(all_done), .at_last(at_last)
  );

  // BUSY sampled at the end of the high phase decides whether to repeat
  assign byte_next = !(CHECK_BUSY && tgt_busy);

  always_comb begin
    state_d  = state_q;
    tmr_clr  = 1'b0;
    cnt_load = 1'b0;
    cnt_inc  = 1'b0;
    dout_ld  = 1'b0;
    rb_ld    = 1'b0;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_load) begin
          cnt_load = 1'b1;
          state_d  = S_L_PROG;
        end else if (start_read) begin
          cnt_load = 1'b1;
          state_d  = S_R_CS;
        end
      end
      S_L_PROG: if (tick) begin
        state_d = S_L_WAIT;
        tmr_clr = 1'b1;
      end
      S_L_WAIT: begin
        if (tgt_ready)    state_d = S_L_WR;
        else if (tmr_exp) begin
          state_d = S_IDLE;
          fin     = 1'b1;
        end
      end
      S_L_WR:  if (tick) state_d = S_L_CS;
      S_L_CS:  if (tick) state_d = S_L_CKH;
      S_L_CKH: if (tick) state_d = all_done ? S_L_ECS : S_L_FETCH;
      S_L_FETCH: if (ld_valid) begin
        dout_ld = 1'b1;
        cnt_inc = 1'b1;
        state_d = S_L_LO;
      end
      S_L_LO: if (tick) state_d = S_L_HI;
      S_L_HI: if (tick) begin
        if (!byte_next) begin
          state_d = S_L_BLO;
          tmr_clr = 1'b1;
        end else begin
          state_d = all_done ? S_L_ECS : S_L_FETCH;
        end
      end
      S_L_BLO: if (tick) state_d = S_L_BHI;
      S_L_BHI: if (tick) begin
        if (!tgt_busy)    state_d = all_done ? S_L_ECS : S_L_FETCH;
        else if (tmr_exp) begin
          state_d = S_IDLE;
          fin     = 1'b1;
        end else          state_d = S_L_BLO;
      end
      S_L_ECS: if (tick) state_d = S_L_EWR;
      S_L_EWR: if (tick) begin
        state_d = S_L_DCHK;
        tmr_clr = 1'b1;
      end
      S_L_DCHK: begin
        if (tgt_done) begin
          state_d = S_IDLE;
          fin     = 1'b1;
          fin_ok  = 1'b1;
        end else if (tmr_exp) begin
          state_d = S_IDLE;
          fin     = 1'b1;
        end else begin
          state_d = S_L_DLO;
        end
      end
      S_L_DLO: if (tick) state_d = S_L_DHI;
      S_L_DHI: if (tick) state_d = S_L_DCHK;
      S_R_CS:  if (tick) state_d = S_R_CKH;
      S_R_CKH: if (tick) state_d = all_done ? S_R_ECS : S_R_LO;
      S_R_LO:  if (tick) state_d = S_R_HI;
      S_R_HI:  if (tick) begin
        rb_ld   = 1'b1;
        state_d = S_R_OUT;
      end
      S_R_OUT: if (rb_ready) begin
        cnt_inc = 1'b1;
        state_d = at_last ? S_R_ECS : S_R_LO;
      end
      S_R_ECS: if (tick) state_d = S_R_FLO;
      S_R_FLO: if (tick) state_d = S_R_FHI;
      S_R_FHI: if (tick) begin
        state_d = S_IDLE;
        fin     = 1'b1;
        fin_ok  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dout_q  <= '0;
      rb_q    <= '0;
      end_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= fin;
      if (fin)     ok_q   <= fin_ok;
      if (dout_ld) dout_q <= ld_data;
      if (rb_ld)   rb_q   <= tgt_din;
    end
  end

  assign tgt_prog = (state_q == S_L_PROG);
  assign tgt_wr   = st_wr(state_q);
  assign tgt_cs   = st_cs(state_q);
  assign tgt_cclk = st_cclk(state_q);
  assign tgt_doe  = st_wr(state_q);
  assign tgt_dout = dout_q;
  assign ld_ready = (state_q == S_L_FETCH);
  assign rb_valid = (state_q == S_R_OUT);
  assign rb_data  = rb_q;
  assign active   = (state_q != S_IDLE);
  assign op_end   = end_q;
  assign op_ok    = ok_q;

endmodule

// File: rtl/cfgm_checker.sv
module cfgm_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tgt_prog,
  input logic          tgt_cs,
  input logic          tgt_wr,
  input logic          tgt_cclk,
  input logic [DW-1:0] tgt_dout,
  input logic          tgt_doe,
  input logic          ld_ready,
  input logic          rb_valid,
  input logic          rb_ready,
  input logic [DW-1:0] rb_data,
  input logic          op_end
);

  // R2
  prog_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_prog |-> (!tgt_cs && !tgt_wr));

  // R3
  wr_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_wr) |-> !tgt_cs);

  // R4
  byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_cclk) && tgt_doe) |-> $stable(tgt_dout));

  // R4
  pull_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (tgt_cclk && tgt_cs && tgt_wr));

  // R6
  cs_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_wr) |-> !tgt_cs);

  // R8
  rb_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_data)));

  // R8
  rb_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> (tgt_cclk && tgt_cs && !tgt_wr && !tgt_doe));

  // R11
  drive_under_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_doe |-> tgt_wr);

  // R13
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_end |-> (!tgt_cs && !tgt_wr && !tgt_doe));

endmodule

bind fpga_cfg_master cfgm_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_prog(tgt_prog), .tgt_cs(tgt_cs),
  .tgt_wr(tgt_wr), .tgt_cclk(tgt_cclk), .tgt_dout(tgt_dout),
  .tgt_doe(tgt_doe), .ld_ready(ld_ready), .rb_valid(rb_valid),
  .rb_ready(rb_ready), .rb_data(rb_data), .op_end(op_end)
);

// File: tb/fpga_cfg_master_tb.sv
module fpga_cfg_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE = 2;
  localparam int TMO   = 200;
  localparam int LW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_load = 1'b0, start_read = 1'b0;
  logic [LW-1:0] xfer_len = '0;
  logic ld_valid = 1'b0, rb_ready = 1'b0;
  logic [7:0] ld_data = '0;
  logic ld_ready, rb_valid;
  logic [7:0] rb_data, tgt_dout;
  logic [7:0] tgt_din = '0;
  logic tgt_prog, tgt_cs, tgt_wr, tgt_cclk, tgt_doe;
  logic tgt_init, tgt_busy, tgt_done, active, op_end, op_ok;

  // task-side configuration
  logic init_boot = 1'b0, busy_boot = 1'b0, in_ld = 1'b0, in_rb = 1'b0;
  int epoch = 0, cfg_n = 0, cfg_salt = 0, cfg_bmax = 0, cfg_gap = 0;
  int cfg_dafter = 1;
  bit cfg_stuck = 1'b0;

  // target model state (posedge of configuration clock)
  int m_ep = -1, ncap = 0, busy_left = 0, d_rises = 0, bad_hold = 0;
  int rb_k = 0, rb_tail = 0;
  logic [7:0] cap [64];
  logic [7:0] cap_last = '0;

  // stream and pin monitor state (negedge of system clock)
  int n_ep = -1, ld_idx = 0, rb_got = 0, ends = 0, prog_run = 0, prog_w = 0;
  int wr_rise = 0, wr_fall = 0, cs_rise = 0, cs_fall = 0, cyc = 0;
  int rb_bad = 0;
  bit ld_pend = 1'b0, last_ok = 1'b0, p_wr = 1'b0, p_cs = 1'b0;
  logic [7:0] got [64];

  int n_chk = 0, n_bad = 0;

  assign tgt_init = init_boot;
  assign tgt_busy = busy_boot | ((m_ep == epoch) && (busy_left > 0));
  assign tgt_done = in_ld && (m_ep == epoch) && (d_rises >= cfg_dafter);

  fpga_cfg_master #(.DW(8), .LEN_W(LW), .PHASE(PHASE), .TIMEOUT(TMO),
                    .CHECK_BUSY(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_read(start_read),
    .xfer_len(xfer_len), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .rb_valid(rb_valid), .rb_data(rb_data),
    .rb_ready(rb_ready), .tgt_prog(tgt_prog), .tgt_cs(tgt_cs),
    .tgt_wr(tgt_wr), .tgt_cclk(tgt_cclk), .tgt_dout(tgt_dout),
    .tgt_doe(tgt_doe), .tgt_din(tgt_din), .tgt_init(tgt_init),
    .tgt_busy(tgt_busy), .tgt_done(tgt_done), .active(active),
    .op_end(op_end), .op_ok(op_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] ld_pat(int k, int s);
    return 8'((k * 29 + s * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] rb_pat(int k, int s);
    return 8'((k * 53 + s * 11 + 5) & 255);
  endfunction

  // target model
  always @(posedge tgt_cclk) begin
    if (m_ep != epoch) begin
      m_ep = epoch; ncap = 0; busy_left = 0; d_rises = 0;
      bad_hold = 0; rb_k = 0; rb_tail = 0;
    end
    if (in_ld && tgt_cs && tgt_wr) begin
      if (busy_left > 0) begin
        busy_left--;
        if (tgt_dout !== cap_last) bad_hold++;
      end else begin
        if (ncap < 64) cap[ncap] = tgt_dout;
        ncap++;
        cap_last = tgt_dout;
        busy_left = cfg_stuck ? (1 << 30) : $urandom_range(cfg_bmax);
      end
    end
    if (in_ld && !tgt_cs && !tgt_wr) d_rises++;
    if (in_rb && tgt_cs && !tgt_wr) begin
      tgt_din = rb_pat(rb_k, cfg_salt);
      rb_k++;
    end
    if (in_rb && !tgt_cs) rb_tail++;
  end

  // streams and pin monitor
  always @(negedge clk) begin
    if (n_ep != epoch) begin
      n_ep = epoch; ld_idx = 0; ld_pend = 1'b0; rb_got = 0; rb_bad = 0;
    end
    if (ld_pend) ld_idx++;
    ld_valid = in_ld && (ld_idx < cfg_n) && ($urandom_range(99) >= 30);
    ld_data  = ld_pat(ld_idx, cfg_salt);
    ld_pend  = ld_valid && ld_ready;
    rb_ready = ($urandom_range(99) >= cfg_gap);
    if (rb_valid && rb_ready) begin
      if (rb_got < 64) got[rb_got] = rb_data;
      rb_got++;
    end
    if (in_rb && (tgt_doe || (rb_valid && !tgt_cclk))) rb_bad++;
    if (tgt_prog) prog_run++;
    else if (prog_run != 0) begin prog_w = prog_run; prog_run = 0; end
    if (tgt_wr && !p_wr) wr_rise = cyc;
    if (!tgt_wr && p_wr) wr_fall = cyc;
    if (tgt_cs && !p_cs) cs_rise = cyc;
    if (!tgt_cs && p_cs) cs_fall = cyc;
    p_wr = tgt_wr; p_cs = tgt_cs;
    if (op_end) begin ends++; last_ok = op_ok; end
  end

  task automatic chk(bit good, string req, int act, int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // hold < 0 keeps the target in initialisation forever
  task automatic do_load(int n, int bmax, bit stuck, int dafter, int hold,
                         int salt, bit poke, output bit ok_o, output int rel_c);
    int e0;
    @(negedge clk);
    epoch++; cfg_n = n; cfg_salt = salt; cfg_bmax = bmax; cfg_stuck = stuck;
    cfg_dafter = dafter; in_ld = 1'b1; init_boot = 1'b1; busy_boot = 1'b1;
    repeat (2) @(negedge clk);
    e0 = ends; xfer_len = LW'(n); start_load = 1'b1;
    @(negedge clk) start_load = 1'b0;
    @(negedge tgt_prog);
    rel_c = 0;
    if (hold >= 0) begin
      repeat (hold) @(negedge clk);
      rel_c = cyc; init_boot = 1'b0; busy_boot = 1'b0;
    end
    if (poke) begin
      @(negedge clk); start_read = 1'b1; start_load = 1'b1;
      @(negedge clk); start_read = 1'b0; start_load = 1'b0;
    end
    while (ends == e0) @(negedge clk);
    ok_o = last_ok;
    repeat (3) @(negedge clk);
    in_ld = 1'b0; init_boot = 1'b0; busy_boot = 1'b0;
  endtask

  task automatic do_read(int n, int gap, int salt, output bit ok_o);
    int e0;
    @(negedge clk);
    epoch++; cfg_salt = salt; cfg_gap = gap; in_rb = 1'b1;
    repeat (2) @(negedge clk);
    e0 = ends; xfer_len = LW'(n); start_read = 1'b1;
    @(negedge clk) start_read = 1'b0;
    while (ends == e0) @(negedge clk);
    ok_o = last_ok;
    repeat (3) @(negedge clk);
    in_rb = 1'b0;
  endtask

  task automatic check_load(int n, int salt, int dafter, int rel_c, bit ok);
    int nc, bad;
    nc = (m_ep == epoch) ? ncap : 0;
    chk(ok == 1'b1, "R7 load outcome", int'(ok), 1);
    chk(prog_w == PHASE, "R2 program pulse width", prog_w, PHASE);
    chk(wr_rise > rel_c, "R2 write waits for ready", wr_rise, rel_c + 1);
    chk(cs_rise - wr_rise == PHASE, "R3 write to select gap", cs_rise - wr_rise, PHASE);
    chk(wr_fall - cs_fall == PHASE, "R6 select to write gap", wr_fall - cs_fall, PHASE);
    chk(nc == n, "R4 bytes captured", nc, n);
    chk(ld_idx == n, "R4 stream handshakes", ld_idx, n);
    bad = 0;
    for (int i = 0; i < n && i < 64; i++) if (cap[i] !== ld_pat(i, salt)) bad++;
    chk(bad == 0, "R4 byte order and value", bad, 0);
    chk(bad_hold == 0, "R5 byte held while busy", bad_hold, 0);
    chk(d_rises == dafter, "R7 pulses until done", d_rises, dafter);
    chk(!tgt_cs && !tgt_wr && !tgt_doe, "R13 released at end",
        int'({tgt_cs, tgt_wr, tgt_doe}), 0);
  endtask

  task automatic check_read(int n, int salt, bit ok);
    int bad;
    chk(ok == 1'b1, "R9 readback outcome", int'(ok), 1);
    chk(rb_got == n, "R8 bytes delivered", rb_got, n);
    bad = 0;
    for (int i = 0; i < n && i < 64; i++) if (got[i] !== rb_pat(i, salt)) bad++;
    chk(bad == 0, "R8 readback values", bad, 0);
    chk(rb_bad == 0, "R8 bus undriven and clock high in stall", rb_bad, 0);
    chk(rb_tail == 1, "R9 one trailing pulse", rb_tail, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog (all)", 0, 1);
    summary();
  end

  initial begin
    bit ok;
    int rel_c, n, s, e0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({tgt_prog, tgt_cs, tgt_wr, tgt_doe, ld_ready, rb_valid, active} == 7'b0,
        "R1 outputs idle", int'({tgt_prog, tgt_cs, tgt_wr, tgt_doe, ld_ready, rb_valid, active}), 0);
    chk(tgt_cclk == 1'b1, "R1 clock idles high", int'(tgt_cclk), 1);

    // directed load, no busy
    do_load(5, 0, 1'b0, 3, 4, 1, 1'b0, ok, rel_c);
    check_load(5, 1, 3, rel_c, ok);

    // random loads with busy throttling
    for (int t = 0; t < 6; t++) begin
      n = $urandom_range(1, 16); s = 10 + t;
      do_load(n, $urandom_range(0, 3), 1'b0, $urandom_range(1, 5),
              $urandom_range(0, 10), s, 1'b0, ok, rel_c);
      check_load(n, s, d_rises, rel_c, ok);
    end

    // R10 zero-length load
    do_load(0, 0, 1'b0, 2, 1, 3, 1'b0, ok, rel_c);
    chk(ok == 1'b1, "R10 empty load succeeds", int'(ok), 1);
    chk(((m_ep == epoch) ? ncap : 0) == 0, "R10 empty load writes nothing",
        (m_ep == epoch) ? ncap : 0, 0);
    chk(wr_rise > rel_c, "R10 empty load still strobes", wr_rise, rel_c + 1);

    // R2 ready timeout
    do_load(4, 0, 1'b0, 1, -1, 4, 1'b0, ok, rel_c);
    chk(ok == 1'b0, "R2 ready timeout fails", int'(ok), 0);
    chk(((m_ep == epoch) ? ncap : 0) == 0, "R2 nothing sent on timeout",
        (m_ep == epoch) ? ncap : 0, 0);
    chk(!tgt_cs && !tgt_wr, "R13 released after timeout", int'({tgt_cs, tgt_wr}), 0);

    // R5 busy timeout
    do_load(3, 0, 1'b1, 1, 0, 5, 1'b0, ok, rel_c);
    chk(ok == 1'b0, "R5 busy timeout fails", int'(ok), 0);
    chk(ncap == 1, "R5 no new byte while busy", ncap, 1);
    chk(ld_idx == 1, "R5 stream stalled while busy", ld_idx, 1);
    chk(!tgt_cs && !tgt_wr && !tgt_doe, "R13 released after busy abort",
        int'({tgt_cs, tgt_wr, tgt_doe}), 0);

    // R7 done timeout
    do_load(2, 0, 1'b0, 1 << 20, 0, 6, 1'b0, ok, rel_c);
    chk(ok == 1'b0, "R7 done timeout fails", int'(ok), 0);
    chk(d_rises > 0, "R7 clocked while waiting for done", d_rises, 1);

    // R12 start pulses ignored while a load runs
    e0 = ends;
    do_load(6, 1, 1'b0, 2, 2, 7, 1'b1, ok, rel_c);
    repeat (20) @(negedge clk);
    chk(ends - e0 == 1, "R12 single end pulse", ends - e0, 1);
    chk(!active, "R12 no second operation", int'(active), 0);
    check_load(6, 7, 2, rel_c, ok);

    // readbacks, directed no-stall then random back-pressure
    do_read(4, 0, 20, ok);
    check_read(4, 20, ok);
    for (int t = 0; t < 4; t++) begin
      n = $urandom_range(1, 16); s = 30 + t;
      do_read(n, $urandom_range(0, 70), s, ok);
      check_read(n, s, ok);
    end

    // R10 zero-length readback
    do_read(0, 0, 40, ok);
    chk(ok == 1'b1, "R10 empty readback succeeds", int'(ok), 1);
    chk(rb_got == 0, "R10 empty readback delivers nothing", rb_got, 0);
    chk(rb_k == 0, "R10 empty readback reads nothing", rb_k, 0);

    summary();
  end
endmodule